// File: doc/BRIEF.md
# Serial PSRAM access controller

This controller connects a simple memory request port to a byte-wide framed serial shifter that drives a serial pseudo-static RAM. Once reset is released it brings the memory device up on its own. It sends a reset-enable command, waits, sends a reset command and waits again. When the block is built for four-line operation it then sends the command that switches the device to quad mode. During this start-up phase the request port is held not ready.

After start-up, each accepted request becomes one frame on the shifter stream. A frame opens with two header bytes: the first gives the length of the outgoing phase and the second gives the length of the returning phase. In quad mode both lengths count nibbles, and in single-line mode they count bits. The header is followed by the command byte, the 24-bit address and then either the write data or a filler byte that covers the read wait cycles. Bytes coming back from the shifter are packed into a read-data word, and completion is signalled by a single-cycle pulse. The block accepts only one transaction at a time. A read therefore always starts after the previous write has been fully handed to the shifter.

Top module: `psc_ctrl`

## Requirements
- R1: While reset is held, `req_ready`, `tx_valid` and `rd_valid` are all 0.
- R2: Start-up frames carry the commands 0x66, 0x99 and then (quad build only) 0x35, in that order. Each has header bytes 8 and 0. In a quad build each command goes out as four payload bytes; byte k (k=0..3) is {3'b0, cmd[7-2k], 3'b0, cmd[6-2k]}, so the first command bit is bit 7 and each nibble is 0 or 1.
- R3: The first byte of the 0x99 frame appears at least 50×CLK_MHZ and at most 50×CLK_MHZ+4 cycles after the last byte of the 0x66 frame is accepted. The next start-up step (the 0x35 frame in quad, request readiness in single-line) follows the last 0x99 byte by at least 100×CLK_MHZ and at most 100×CLK_MHZ+4 cycles.
- R4: `req_ready` is 0 during start-up and while a frame is being sent or read bytes are awaited. Otherwise it is 1: within 4 cycles after start-up ends, and in the cycle after the last frame byte of a write or the last read byte is taken.
- R5: A quad write frame is [(4+n)×2, 0, 0x38, addr[23:16], addr[15:8], addr[7:0], data byte 0 … data byte n-1]. Data byte i is `req_wdata[8i+7:8i]`, so the least significant byte goes first.
- R6: A quad read frame is [10, n×2, 0xEB, addr[23:16], addr[15:8], addr[7:0], 0xFF].
- R7: `req_size` codes 0, 1, 2 and 3 select n = 1, 2, 4 and 8 bytes.
- R8: Returned bytes are stored little-endian: byte i goes to `rd_data[8i+7:8i]`, and the bytes above n are 0. `rd_valid` is high for exactly one cycle, the cycle after the last byte arrives.
- R9: A read request offered while a write frame is in progress is accepted only after that write's last byte has been accepted by the shifter.
- R10: A single-line build (QUAD=0) sends each start-up command as one plain byte, sends no 0x35, and uses 0x02 and 0x0B as commands. Its header lengths are in bits: a write has [(4+n)×8, 0] and a read has [40, n×8].
- R11: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_size | input | 2 | Byte count code (1, 2, 4, 8) |
| req_wdata | input | 64 | Write data, byte 0 in bits 7:0 |
| rd_valid | output | 1 | One-cycle read completion pulse |
| rd_data | output | 64 | Assembled read data |
| tx_valid | output | 1 | Frame byte available to shifter |
| tx_data | output | 8 | Frame byte |
| tx_ready | input | 1 | Shifter takes the byte |
| rx_valid | input | 1 | Returned byte present |
| rx_data | input | 8 | Returned byte |

## Verification
The assertions assume that the shifter returns read bytes only after the read frame has been fully sent, and that it returns exactly the number of bytes the header asked for. They assume nothing about `tx_ready`, which may stall at any time. The bench's shifter model starts feeding returned bytes only after it has parsed the complete read frame, and it feeds exactly n of them. It also stalls deliberately in the middle of a frame. Requests are held on the port until they are accepted, and a read is also offered while a write frame is still draining.

// File: rtl/psc_pkg.sv
package psc_pkg;
    localparam int ADDR_W      = 24;
    localparam int MAX_BYTES   = 8;
    localparam int DATA_W      = 8 * MAX_BYTES;
    localparam int CNT_W       = $clog2(MAX_BYTES + 1);
    localparam int SEL_W       = $clog2(MAX_BYTES);
    localparam int HDR_BYTES   = 2;
    localparam int FRAME_BYTES = HDR_BYTES + 4 + MAX_BYTES;
    localparam int LEN_W       = $clog2(FRAME_BYTES + 1);

    localparam logic [7:0] OP_RST_EN  = 8'h66;
    localparam logic [7:0] OP_RST     = 8'h99;
    localparam logic [7:0] OP_QUAD_ON = 8'h35;
    localparam logic [7:0] OP_WR_QUAD = 8'h38;
    localparam logic [7:0] OP_WR_ONE  = 8'h02;
    localparam logic [7:0] OP_RD_QUAD = 8'hEB;
    localparam logic [7:0] OP_RD_ONE  = 8'h0B;
    localparam logic [7:0] WAIT_FILL  = 8'hFF;

    typedef enum logic [1:0] {C_INIT, C_IDLE, C_SEND, C_RECV} ctrl_state_e;
    typedef enum logic [1:0] {I_SEND, I_SHIFT, I_PAUSE, I_DONE} init_state_e;

    typedef struct packed {
        logic [FRAME_BYTES-1:0][7:0] b;
        logic [LEN_W-1:0]            len;
    } frame_t;

    function automatic logic [CNT_W-1:0] size_to_bytes(input logic [1:0] code);
        return CNT_W'(1) << code;
    endfunction

    function automatic frame_t cmd_frame(input logic [7:0] op, input logic quad);
        frame_t f;
        f = '0;
        f.b[0] = 8'd8;
        if (quad) begin
            for (int k = 0; k < 4; k++)
                f.b[HDR_BYTES+k] = {3'b000, op[7-2*k], 3'b000, op[6-2*k]};
            f.len = LEN_W'(HDR_BYTES + 4);
        end else begin
            f.b[HDR_BYTES] = op;
            f.len = LEN_W'(HDR_BYTES + 1);
        end
        return f;
    endfunction

    function automatic frame_t write_frame(input logic [ADDR_W-1:0] addr,
                                           input logic [DATA_W-1:0] data,
                                           input logic [CNT_W-1:0] n,
                                           input logic quad);
        frame_t f;
        f = '0;
        f.b[0] = (8'(n) + 8'd4) << (quad ? 1 : 3);
        f.b[2] = quad ? OP_WR_QUAD : OP_WR_ONE;
        f.b[3] = addr[23:16];
        f.b[4] = addr[15:8];
        f.b[5] = addr[7:0];
        for (int i = 0; i < MAX_BYTES; i++)
            if (i < int'(n)) f.b[6+i] = data[8*i +: 8];
        f.len = LEN_W'(6) + LEN_W'(n);
        return f;
    endfunction

    function automatic frame_t read_frame(input logic [ADDR_W-1:0] addr,
                                          input logic [CNT_W-1:0] n,
                                          input logic quad);
        frame_t f;
        f = '0;
        f.b[0] = quad ? 8'd10 : 8'd40;
        f.b[1] = 8'(n) << (quad ? 1 : 3);
        f.b[2] = quad ? OP_RD_QUAD : OP_RD_ONE;
        f.b[3] = addr[23:16];
        f.b[4] = addr[15:8];
        f.b[5] = addr[7:0];
        f.b[6] = WAIT_FILL;
        f.len = LEN_W'(7);
        return f;
    endfunction
endpackage

// File: rtl/psc_serializer.sv
module psc_serializer
    import psc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  frame_t     frame_in,
    output logic       busy,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    output logic       last_acc
);
    frame_t           cur;
    logic [LEN_W-1:0] idx;

    assign tx_data  = cur.b[idx];
    assign last_acc = busy && tx_ready && (idx == cur.len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
            cur  <= '0;
        end else if (load && !busy) begin
            cur  <= frame_in;
            idx  <= '0;
            busy <= 1'b1;
        end else if (last_acc) begin
            busy <= 1'b0;
        end else if (busy && tx_ready) begin
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/psc_init_seq.sv
module psc_init_seq
    import psc_pkg::*;
#(
    parameter bit QUAD  = 1'b1,
    parameter int WAIT1 = 6250,
    parameter int WAIT2 = 12500
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   ser_last,
    output logic   load,
    output frame_t frame,
    output logic   done
);
    localparam int CNT_MAX = (WAIT1 > WAIT2) ? WAIT1 : WAIT2;
    localparam int CW      = $clog2(CNT_MAX + 1);

    init_state_e   state;
    logic [1:0]    step;
    logic [CW-1:0] cnt;
    logic [7:0]    op;

    always_comb begin
        case (step)
            2'd0:    op = OP_RST_EN;
            2'd1:    op = OP_RST;
            default: op = OP_QUAD_ON;
        endcase
    end

    assign frame = cmd_frame(op, QUAD);
    assign load  = (state == I_SEND);
    assign done  = (state == I_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= I_SEND;
            step  <= 2'd0;
            cnt   <= '0;
        end else begin
            case (state)
                I_SEND: state <= I_SHIFT;
                I_SHIFT: if (ser_last) begin
                    if (step == 2'd0) begin
                        cnt   <= CW'(WAIT1 - 1);
                        step  <= 2'd1;
                        state <= I_PAUSE;
                    end else if (step == 2'd1) begin
                        cnt   <= CW'(WAIT2 - 1);
                        step  <= 2'd2;
                        state <= I_PAUSE;
                    end else begin
                        state <= I_DONE;
                    end
                end
                I_PAUSE: begin
                    if (cnt == '0)
                        state <= (step == 2'd2 && !QUAD) ? I_DONE : I_SEND;
                    else
                        cnt <= cnt - 1'b1;
                end
                default: state <= I_DONE;
            endcase
        end
    end
endmodule

// File: rtl/psc_rx_gather.sv
module psc_rx_gather
    import psc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  nbytes,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              fin
);
    logic             active;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] need;

    assign fin = active && rx_valid && (cnt == need - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            cnt      <= '0;
            need     <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (start) begin
                active  <= 1'b1;
                cnt     <= '0;
                need    <= nbytes;
                rd_data <= '0;
            end else if (active && rx_valid) begin
                rd_data[{cnt[SEL_W-1:0], 3'b000} +: 8] <= rx_data;
                if (fin) begin
                    active   <= 1'b0;
                    rd_valid <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/psc_ctrl.sv
module psc_ctrl
    import psc_pkg::*;
#(
    parameter int CLK_MHZ     = 125,
    parameter bit QUAD        = 1'b1,
    parameter int EN_WAIT_US  = 50,
    parameter int RST_WAIT_US = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data
);
    localparam int WAIT1_CYC = EN_WAIT_US * CLK_MHZ;
    localparam int WAIT2_CYC = RST_WAIT_US * CLK_MHZ;
    localparam int INIT_CYC  = WAIT1_CYC + WAIT2_CYC;

    ctrl_state_e      state;
    logic             is_read;
    logic             init_load, init_done, ser_last, rx_fin, accept;
    frame_t           init_frame, req_frame, ser_frame;
    logic [CNT_W-1:0] nbytes;

    assign req_ready = (state == C_IDLE);
    assign accept    = req_valid && req_ready;
    assign nbytes    = size_to_bytes(req_size);
    assign req_frame = req_write ? write_frame(req_addr, req_wdata, nbytes, QUAD)
                                 : read_frame(req_addr, nbytes, QUAD);
    assign ser_frame = (state == C_INIT) ? init_frame : req_frame;

    psc_init_seq #(.QUAD(QUAD), .WAIT1(WAIT1_CYC), .WAIT2(WAIT2_CYC)) u_init (
        .clk(clk), .rst(rst), .ser_last(ser_last),
        .load(init_load), .frame(init_frame), .done(init_done)
    );

    psc_serializer u_ser (
        .clk(clk), .rst(rst),
        .load((state == C_INIT) ? init_load : accept),
        .frame_in(ser_frame), .busy(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .last_acc(ser_last)
    );

    psc_rx_gather u_rx (
        .clk(clk), .rst(rst), .start(accept && !req_write), .nbytes(nbytes),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .fin(rx_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= C_INIT;
            is_read <= 1'b0;
        end else begin
            case (state)
                C_INIT: if (init_done) state <= C_IDLE;
                C_IDLE: if (req_valid) begin
                    state   <= C_SEND;
                    is_read <= !req_write;
                end
                C_SEND: if (ser_last) state <= is_read ? C_RECV : C_IDLE;
                default: if (rx_fin) state <= C_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/psc_ctrl_chk.sv
module psc_ctrl_chk #(
    parameter int INIT_MIN = 18750
) (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       tx_valid,
    input logic [7:0] tx_data,
    input logic       tx_ready,
    input logic       rd_valid,
    input logic       rx_valid
);
    logic [31:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 32'hFFFF_FFFF) since_rst <= since_rst + 1;
    end

    // R11
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R11
    tx_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_valid) |-> $past(tx_ready));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !tx_valid);

    // R3
    init_time_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (since_rst >= 32'(INIT_MIN)));

    // R8
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R8
    rd_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(rx_valid) && !$past(req_ready)));
endmodule

bind psc_ctrl psc_ctrl_chk #(.INIT_MIN(INIT_CYC)) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rd_valid(rd_valid), .rx_valid(rx_valid)
);

// File: tb/psc_ctrl_test.sv
module psc_ctrl_test;
    localparam int W1 = 50 * 125;
    localparam int W2 = 100 * 125;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    logic sel = 1'b0;

    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        shf_ready = 1'b0, rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;

    logic        q_ready, q_rdv, q_txv, s_ready, s_rdv, s_txv;
    logic [63:0] q_rdd, s_rdd;
    logic [7:0]  q_txd, s_txd;

    logic        cur_ready, cur_rdv, cur_txv;
    logic [63:0] cur_rdd;
    logic [7:0]  cur_txd;
    assign cur_ready = sel ? s_ready : q_ready;
    assign cur_rdv   = sel ? s_rdv : q_rdv;
    assign cur_txv   = sel ? s_txv : q_txv;
    assign cur_rdd   = sel ? s_rdd : q_rdd;
    assign cur_txd   = sel ? s_txd : q_txd;

    psc_ctrl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid && !sel), .req_ready(q_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rd_valid(q_rdv), .rd_data(q_rdd),
        .tx_valid(q_txv), .tx_data(q_txd), .tx_ready(shf_ready && !sel),
        .rx_valid(rx_valid && !sel), .rx_data(rx_data)
    );

    psc_ctrl #(.QUAD(1'b0)) uut_spi (
        .clk(clk), .rst(rst), .req_valid(req_valid && sel), .req_ready(s_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rd_valid(s_rdv), .rd_data(s_rdd),
        .tx_valid(s_txv), .tx_data(s_txd), .tx_ready(shf_ready && sel),
        .rx_valid(rx_valid && sel), .rx_data(rx_data)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    logic [7:0] fr [16];
    int         fr_n, fr_tf, fr_tl;
    logic       mid_ready;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic take_byte(output logic [7:0] b, output int t);
        do @(negedge clk); while (!cur_txv);
        b = cur_txd;
        t = cyc;
        shf_ready = 1'b1;
        @(negedge clk);
        shf_ready = 1'b0;
    endtask

    task automatic take_frame();
        int t, pay;
        take_byte(fr[0], fr_tf);
        take_byte(fr[1], t);
        mid_ready = cur_ready;
        pay = int'(fr[0]) / (sel ? 8 : 2);
        if (pay > 14) pay = 14;
        fr_tl = t;
        for (int i = 0; i < pay; i++) take_byte(fr[2+i], fr_tl);
        fr_n = 2 + pay;
    endtask

    task automatic do_req(input logic we, input logic [23:0] a, input logic [1:0] sz,
                          input logic [63:0] d, output int t_acc);
        @(negedge clk);
        req_valid = 1'b1; req_write = we; req_addr = a; req_size = sz; req_wdata = d;
        while (!cur_ready) @(negedge clk);
        t_acc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check_cmd(input logic [7:0] op, input string req);
        chk(fr[0] == 8'd8 && fr[1] == 8'd0, req, "command header", {fr[0], fr[1]}, 16'h0800);
        if (!sel) begin
            chk(fr_n == 6, req, "quad command length", fr_n, 6);
            for (int k = 0; k < 4; k++)
                chk(fr[2+k] == {3'b000, op[7-2*k], 3'b000, op[6-2*k]}, req, "command nibble pair",
                    fr[2+k], {3'b000, op[7-2*k], 3'b000, op[6-2*k]});
        end else begin
            chk(fr_n == 3 && fr[2] == op, req, "single command byte", fr[2], op);
        end
        chk(mid_ready == 1'b0, "R4", "ready during start-up", mid_ready, 0);
    endtask

    task automatic t_init();
        int tl, gap, t;
        string rq;
        rq = sel ? "R10" : "R2";
        take_frame(); check_cmd(8'h66, rq);
        tl = fr_tl;
        take_frame(); check_cmd(8'h99, rq);
        gap = fr_tf - tl - 1;
        chk(gap >= W1 && gap <= W1 + 4, "R3", "first wait", gap, W1);
        tl = fr_tl;
        if (!sel) begin
            take_frame(); check_cmd(8'h35, "R2");
            gap = fr_tf - tl - 1;
            chk(gap >= W2 && gap <= W2 + 4, "R3", "second wait", gap, W2);
            t = 0;
            while (!cur_ready && t < 10) begin @(negedge clk); t++; end
            chk(t <= 4, "R4", "ready after start-up", t, 4);
        end else begin
            t = 0;
            while (!cur_ready && t < W2 + 20) begin @(negedge clk); t++; end
            gap = cyc - tl - 1;
            chk(gap >= W2 && gap <= W2 + 4, "R3", "second wait single", gap, W2);
        end
    endtask

    task automatic t_write(input logic [23:0] a, input logic [1:0] sz, input logic [63:0] d);
        int n, t, mult;
        n = 1 << sz;
        mult = sel ? 8 : 2;
        do_req(1'b1, a, sz, d, t);
        take_frame();
        chk(fr_n == 6 + n, "R7", "write frame size", fr_n, 6 + n);
        chk(fr[0] == 8'((4 + n) * mult) && fr[1] == 8'd0, sel ? "R10" : "R5",
            "write header", {fr[0], fr[1]}, {8'((4 + n) * mult), 8'd0});
        chk(fr[2] == (sel ? 8'h02 : 8'h38), sel ? "R10" : "R5", "write command", fr[2],
            sel ? 8'h02 : 8'h38);
        chk({fr[3], fr[4], fr[5]} == a, "R5", "write address", {fr[3], fr[4], fr[5]}, a);
        for (int i = 0; i < n; i++)
            chk(fr[6+i] == d[8*i +: 8], "R5", "write data byte", fr[6+i], d[8*i +: 8]);
        chk(mid_ready == 1'b0, "R4", "ready during write", mid_ready, 0);
        chk(cur_ready == 1'b1, "R4", "ready after write", cur_ready, 1);
    endtask

    task automatic feed_rx(input int n, input logic [63:0] v);
        logic [63:0] exp;
        exp = '0;
        for (int i = 0; i < n; i++) exp[8*i +: 8] = v[8*i +: 8];
        chk(cur_ready == 1'b0, "R4", "ready while awaiting read", cur_ready, 0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(cur_rdv == 1'b0, "R8", "early rd_valid", cur_rdv, 0);
            rx_valid = 1'b1; rx_data = v[8*i +: 8];
        end
        @(negedge clk);
        rx_valid = 1'b0;
        chk(cur_rdv == 1'b1, "R8", "rd_valid pulse", cur_rdv, 1);
        chk(cur_rdd == exp, "R8", "read data", cur_rdd, exp);
        @(negedge clk);
        chk(cur_rdv == 1'b0, "R8", "rd_valid single cycle", cur_rdv, 0);
        chk(cur_ready == 1'b1, "R4", "ready after read", cur_ready, 1);
    endtask

    task automatic check_read_frame(input logic [23:0] a, input int n);
        int mult;
        mult = sel ? 8 : 2;
        chk(fr_n == 7, "R6", "read frame size", fr_n, 7);
        chk(fr[0] == (sel ? 8'd40 : 8'd10) && fr[1] == 8'(n * mult), sel ? "R10" : "R6",
            "read header", {fr[0], fr[1]}, {(sel ? 8'd40 : 8'd10), 8'(n * mult)});
        chk(fr[2] == (sel ? 8'h0B : 8'hEB), sel ? "R10" : "R6", "read command", fr[2],
            sel ? 8'h0B : 8'hEB);
        chk({fr[3], fr[4], fr[5]} == a && fr[6] == 8'hFF, "R6", "read address and filler",
            {fr[3], fr[4], fr[5], fr[6]}, {a, 8'hFF});
    endtask

    task automatic t_read(input logic [23:0] a, input logic [1:0] sz, input logic [63:0] v);
        int t;
        do_req(1'b0, a, sz, 64'd0, t);
        take_frame();
        check_read_frame(a, 1 << sz);
        feed_rx(1 << sz, v);
    endtask

    task automatic t_order();
        int t, t_rd;
        do_req(1'b1, 24'h00ABCD, 2'd2, 64'hCAFEF00D, t);
        fork
            take_frame();
            do_req(1'b0, 24'h123456, 2'd0, 64'd0, t_rd);
        join
        chk(fr[2] == 8'h38, "R9", "write frame first", fr[2], 8'h38);
        chk(t_rd > fr_tl, "R9", "read accepted after write drained", t_rd, fr_tl + 1);
        take_frame();
        check_read_frame(24'h123456, 1);
        feed_rx(1, 64'h5A);
    endtask

    task automatic t_stall();
        int t;
        logic [7:0] d0;
        do_req(1'b1, 24'h000010, 2'd0, 64'h77, t);
        d0 = cur_txd;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(cur_txv == 1'b1 && cur_txd == d0, "R11", "stalled byte held", cur_txd, d0);
        end
        take_frame();
        chk(fr[0] == 8'd10 && d0 == 8'd10, "R11", "stalled header", d0, 10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(q_ready == 0 && q_txv == 0 && q_rdv == 0, "R1", "quad outputs in reset",
            {q_ready, q_txv, q_rdv}, 0);
        chk(s_ready == 0 && s_txv == 0 && s_rdv == 0, "R1", "single outputs in reset",
            {s_ready, s_txv, s_rdv}, 0);
        rst = 1'b0;
        t_init();
        t_write(24'h010203, 2'd0, 64'h00000000000000A5);
        t_write(24'hFEDCBA, 2'd1, 64'h000000000000BEEF);
        t_write(24'h000100, 2'd2, 64'h00000000DEADBEEF);
        t_write(24'h7FFFFF, 2'd3, 64'h0123456789ABCDEF);
        t_read(24'h000004, 2'd0, 64'h00000000000000C3);
        t_read(24'h0A0B0C, 2'd2, 64'hFFFFFFFF11223344);
        t_read(24'hFFFFFF, 2'd3, 64'h8877665544332211);
        t_order();
        t_stall();
        sel = 1'b1;
        t_init();
        t_write(24'h112233, 2'd2, 64'h00000000A1B2C3D4);
        t_read(24'h445566, 2'd1, 64'h000000000000E1F2);
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog: cycles %0d expected below %0d", cyc, 190000);
        summary();
        $finish;
    end
endmodule